// File: doc/BRIEF.md
# Burst Address Sequencer

This block forms the address path of a synchronous burst memory. On every rising clock edge it looks at two active-low load strobes, an active-low advance input, a group of three chip enables and a static burst-order select. From these it decides whether to capture a new base address, step through a four-beat burst, or keep the current address. The address it presents to the memory array comes straight from registers and has no combinational path from the address inputs.

The two strobes follow different gating rules. The processor strobe counts only while the master chip enable is active. When the master enable is inactive, that strobe is ignored completely, so the advance input still acts on that edge. The controller strobe always counts. A controller strobe that finds any chip enable inactive gives a deselect edge, and the address is held. A separate two-bit beat counter is combined with the low bits of the base address. The combination is XOR when the order select is high and a wrap-around add when it is low. The upper address bits stay at the loaded base for the whole burst.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-low reset drives the output address to zero on the edge where it is sampled low, in either burst order.
- R2: A controller strobe low while all three enables are active (master enable low, high-side enable high, low-side enable low) makes the output equal the address input after that edge.
- R3: A processor strobe low while all three enables are active loads the address input in the same way.
- R4: A processor strobe low while the master enable is high has no effect: the edge behaves as if no strobe were present, so advance low still steps the burst.
- R5: A strobe that counts (controller strobe, or processor strobe with master enable low), while any enable is inactive, is a deselect edge: the output address is held and advance is not acted on.
- R6: With no counting strobe, advance low moves the burst to its next beat and advance high holds the output unchanged.
- R7: With order select high, the two low output bits equal the base's low two bits XOR the beat count (0,1,2,3).
- R8: With order select low, the two low output bits equal the base's low two bits plus the beat count, modulo 4.
- R9: After the fourth beat the count wraps to 0, so the first beat's address returns. The bits above the low two never change except on a load.
- R10: When a counting strobe with all enables active meets advance low on the same edge, the load wins and the beat count restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | Base address captured on a load |
| strb_proc_n | input | 1 | Processor load strobe, active low, gated by the master enable |
| strb_ctrl_n | input | 1 | Controller load strobe, active low, never gated |
| adv_n | input | 1 | Advance to the next beat, active low |
| ce_master_n | input | 1 | Master chip enable, active low |
| ce_sec_hi | input | 1 | Secondary chip enable, active high |
| ce_sec_lo_n | input | 1 | Secondary chip enable, active low |
| order_sel | input | 1 | Burst order: 1 = XOR interleave (default), 0 = linear add |
| addr_out | output | ADDR_W | Registered address toward the memory array |

## Verification
Each load, step, hold or reset decision takes effect on the rising edge where its inputs are sampled. The new address is visible at the outputs one edge after the inputs were applied, and the order select acts on the low bits with no added delay. The bench applies each stimulus on a falling edge and pushes the address expected after the next rising edge into a queue. A monitor pops that entry 1 ns after the rising edge and compares, so every result is checked exactly one cycle after its stimulus, never earlier and never later.

// File: rtl/bas_pkg.sv
// Package: shared types of the burst address sequencer.
// Assumes: the three edge decisions cover all that the address path needs.
package bas_pkg;
    // Decision taken on one clock edge
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,  // keep address (wait state or deselect)
        CMD_LOAD = 2'd1,  // capture new base, restart beat count
        CMD_STEP = 2'd2   // advance to next beat
    } cmd_e;
endpackage

// File: rtl/bas_strobe_decode.sv
// Module: bas_strobe_decode
// Turns strobes, enables and advance into one edge decision.
// Assumes: inputs are stable around the rising edge; clk and rst_n are
// used only by the local assertions.
module bas_strobe_decode
    import bas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strb_proc_n,
    input  logic strb_ctrl_n,
    input  logic adv_n,
    input  logic ce_master_n,
    input  logic ce_sec_hi,
    input  logic ce_sec_lo_n,
    output cmd_e cmd
);
    logic proc_counts;
    logic ctrl_counts;
    logic all_enabled;

    // Purpose: qualify each strobe and the enable group
    always_comb begin
        proc_counts = !strb_proc_n && !ce_master_n;
        ctrl_counts = !strb_ctrl_n;
        all_enabled = !ce_master_n && ce_sec_hi && !ce_sec_lo_n;
    end

    // Purpose: pick the edge decision, strobes before advance
    always_comb begin
        if (proc_counts || ctrl_counts) begin
            cmd = all_enabled ? CMD_LOAD : CMD_HOLD;
        end else if (!adv_n) begin
            cmd = CMD_STEP;
        end else begin
            cmd = CMD_HOLD;
        end
    end

    // R4: with master disabled and no controller strobe, nothing loads
    assert_proc_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_ctrl_n && ce_master_n) |-> (cmd != CMD_LOAD));

    // R5: controller strobe with master disabled is a deselect
    assert_ctrl_desel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctrl_n && ce_master_n) |-> (cmd == CMD_HOLD));
endmodule

// File: rtl/bas_beat_counter.sv
// Module: bas_beat_counter
// Beat counter of BEAT_W bits that wraps and does not carry into the
// address. Assumes: cmd comes from bas_strobe_decode.
module bas_beat_counter
    import bas_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    output logic [BEAT_W-1:0] cnt
);
    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    // Purpose: restart on load, step on advance, wrap naturally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cmd == CMD_LOAD) begin
            cnt <= '0;
        end else if (cmd == CMD_STEP) begin
            cnt <= cnt + ONE;
        end
    end

    // R10: a load restarts the count
    assert_cnt_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD) |=> (cnt == '0));

    // R6 / R9: a step adds one modulo the beat count
    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP) |=> (cnt == BEAT_W'($past(cnt) + ONE)));
endmodule

// File: rtl/bas_base_reg.sv
// Module: bas_base_reg
// Holds the loaded base address. Assumes: only a load changes it.
module bas_base_reg
    import bas_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base
);
    // Purpose: capture the address input on a load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
        end else if (cmd == CMD_LOAD) begin
            base <= addr_in;
        end
    end

    // R5: without a load the base does not move
    assert_base_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_LOAD) |=> $stable(base));
endmodule

// File: rtl/bas_order_map.sv
// Module: bas_order_map
// Combines the base's low bits with the beat count in the selected order.
// Assumes: order_sel is static while a burst runs.
module bas_order_map #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] base_lo,
    input  logic [BEAT_W-1:0] cnt,
    input  logic              order_sel,
    output logic [BEAT_W-1:0] lo_out
);
    logic [BEAT_W-1:0] lo_xor;
    logic [BEAT_W-1:0] lo_add;

    // Purpose: form both orders and select one
    always_comb begin
        lo_xor = base_lo ^ cnt;
        lo_add = base_lo + cnt;
        lo_out = order_sel ? lo_xor : lo_add;
    end
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Address path of a synchronous burst memory: load, step or hold.
// Assumes: ADDR_W > BEAT_W; order_sel is tied or static.
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strb_proc_n,
    input  logic              strb_ctrl_n,
    input  logic              adv_n,
    input  logic              ce_master_n,
    input  logic              ce_sec_hi,
    input  logic              ce_sec_lo_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BEAT_W;

    cmd_e              cmd;
    logic [BEAT_W-1:0] cnt;
    logic [ADDR_W-1:0] base;
    logic [BEAT_W-1:0] lo_bits;

    bas_strobe_decode u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .strb_proc_n (strb_proc_n),
        .strb_ctrl_n (strb_ctrl_n),
        .adv_n       (adv_n),
        .ce_master_n (ce_master_n),
        .ce_sec_hi   (ce_sec_hi),
        .ce_sec_lo_n (ce_sec_lo_n),
        .cmd         (cmd)
    );

    bas_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .cnt   (cnt)
    );

    bas_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .addr_in (addr_in),
        .base    (base)
    );

    bas_order_map #(.BEAT_W(BEAT_W)) u_map (
        .base_lo   (base[BEAT_W-1:0]),
        .cnt       (cnt),
        .order_sel (order_sel),
        .lo_out    (lo_bits)
    );

    // Purpose: assemble the output from fixed upper bits and mapped low bits
    always_comb begin
        addr_out = {base[ADDR_W-1:BEAT_W], lo_bits};
    end

    // R2 / R3: a load shows the captured address one edge later
    assert_load_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD) |=> (addr_out == $past(addr_in)));

    // R9: upper bits change only on a load
    assert_upper_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_LOAD) |=> (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));

    // R1: the edge after reset gives a zero address
    assert_reset_zero_R1: assert property (@(posedge clk)
        (!rst_n) |=> (addr_out == '0));

    // R6: a wait state with a steady order select keeps the output
    assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_HOLD) && (HI_W > 0)) |=> ((addr_out == $past(addr_out)) || (order_sel != $past(order_sel))));
endmodule

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          strb_proc_n = 1'b1, strb_ctrl_n = 1'b1, adv_n = 1'b1;
    logic          ce_master_n = 1'b1, ce_sec_hi = 1'b0, ce_sec_lo_n = 1'b1;
    logic          order_sel = 1'b1;
    logic [AW-1:0] addr_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;

    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    burst_addr_seq u0 (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
        .ce_master_n(ce_master_n), .ce_sec_hi(ce_sec_hi), .ce_sec_lo_n(ce_sec_lo_n),
        .order_sel(order_sel), .addr_out(addr_out)
    );

    // driver: apply one edge of stimulus and push the expected result
    task automatic drive(input logic rst, input logic sp, input logic sc,
                         input logic adv, input logic cem, input logic ceh,
                         input logic cel, input logic [AW-1:0] a,
                         input logic ord, input string tag);
        logic [1:0] lo;
        logic proc_c, ctrl_c, sel;
        @(negedge clk);
        rst_n = rst; strb_proc_n = sp; strb_ctrl_n = sc; adv_n = adv;
        ce_master_n = cem; ce_sec_hi = ceh; ce_sec_lo_n = cel;
        addr_in = a; order_sel = ord;
        if (!rst) begin
            m_base = '0; m_cnt = '0;
        end else begin
            proc_c = !sp && !cem;
            ctrl_c = !sc;
            sel = !cem && ceh && !cel;
            if (proc_c || ctrl_c) begin
                if (sel) begin m_base = a; m_cnt = '0; end
            end else if (!adv) begin
                m_cnt = m_cnt + 2'd1;
            end
        end
        lo = ord ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        exp_q.push_back({m_base[AW-1:2], lo});
        tag_q.push_back(tag);
    endtask

    // monitor: compare one result 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [AW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (addr_out !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", t, addr_out, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset
        drive(0,1,1,1,1,0,1,'0,1,"R1 reset");
        drive(0,1,1,1,1,0,1,'0,1,"R1 reset hold");
        // R2 controller load, interleave, low bits 01
        drive(1,1,0,1,0,1,0,18'h2A5B5,1,"R2 ctrl load");
        drive(1,1,1,0,0,1,0,'0,1,"R7 beat1 xor");
        drive(1,1,1,0,0,1,0,'0,1,"R7 beat2 xor");
        drive(1,1,1,1,0,1,0,'0,1,"R6 wait hold");
        drive(1,1,1,0,0,1,0,'0,1,"R7 beat3 xor");
        drive(1,1,1,0,0,1,0,'0,1,"R9 wrap to first");
        // R3 processor load
        drive(1,0,1,1,0,1,0,18'h0137F,1,"R3 proc load");
        // R4 processor strobe ignored, advance steps
        drive(1,0,1,0,1,1,0,18'h3FFFF,1,"R4 proc ignored");
        // R5 controller strobe deselect, advance blocked
        drive(1,1,0,0,1,1,0,18'h11111,1,"R5 ctrl master off");
        drive(1,1,0,0,0,0,0,18'h22222,1,"R5 ctrl sec hi off");
        drive(1,0,1,0,0,1,1,18'h33333,1,"R5 proc sec lo off");
        // R8 linear order, base low bits 01
        drive(1,1,0,1,0,1,0,18'h0C001,0,"R2 load linear");
        drive(1,1,1,0,0,1,0,'0,0,"R8 beat1 add");
        drive(1,1,1,0,0,1,0,'0,0,"R8 beat2 add");
        drive(1,1,1,0,0,1,0,'0,0,"R8 beat3 add");
        drive(1,1,1,0,0,1,0,'0,0,"R9 wrap linear");
        // R9 no carry from low bits 11
        drive(1,1,0,1,0,1,0,18'h1FFFF,0,"R2 load top");
        drive(1,1,1,0,0,1,0,'0,0,"R9 no carry");
        // R10 strobe beats advance mid-burst
        drive(1,1,1,0,0,1,0,'0,0,"R6 step");
        drive(1,0,1,0,0,1,0,18'h05552,0,"R10 load wins");
        drive(1,1,1,0,0,1,0,'0,0,"R10 count restarted");
        // R1 reset mid-burst
        drive(0,1,1,0,0,1,0,'0,1,"R1 reset mid burst");
        drive(1,1,1,1,0,1,0,'0,1,"R1 after reset");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule